// File: doc/BRIEF.md
# Spatial LFSR Dither Unit

This block narrows a stream of 12-bit colour pixels to 6 or 8 bits per channel. Before the low bits are dropped, it adds a small pseudo-random offset to each channel. This spreads the quantisation error in space, so a wide gradient shows fine grain rather than visible bands. Each of the three channels draws its offset from its own 28-bit linear feedback shift register (LFSR). Each register starts from a seed that is set per channel.

The block sits in a display output pipe, just after the pixel source and before the link encoder. It receives a pixel stream with a valid qualifier and two strobes, one for the first pixel of a frame and one for the first pixel of a line. Its configuration is static: enable, a depth code, a shared-or-separate feedback choice, per-frame reseeding, a high-pass option and three seeds. Every result is registered exactly once, and the strobes travel alongside the data.

Top module: `pix_lfsr_dither`

## Requirements
- R1: Depth code 0 produces 6-bit channels, carried in bits 5:0 of each output with bits 7:6 at zero. Depth code 1 produces 8-bit channels. Depth codes 2 and 3 switch dithering off and give plain truncation to 8 bits.
- R2: With the enable low, each output is the top bits of its input, 6 or 8 bits as the depth code selects, and no offset is added.
- R3: An LFSR step maps state s to {s[26:0], s[27]^s[t-1]}. In shared mode t is 3 for all channels. In separate mode t is 3 for red, 9 for green and 13 for blue.
- R4: Reset loads each channel's register with its own seed. A load value of zero is replaced by 1, so a register never holds zero.
- R5: Each register steps once per valid pixel. The raw offset for a pixel is bits 5:0 of the register state before that step. At depth code 1 only bits 3:0 of the offset are used.
- R6: With per-frame reseeding on, a valid pixel carrying the frame strobe uses the load value seed XOR bit-reversed 4-bit frame count (count in bits 3:0) in place of the register state. The count then advances modulo 16. With reseeding off, no reload happens and the count is held at 0.
- R7: With the high-pass option on, the offset is the raw offset XOR the previous valid pixel's raw offset. The previous offset is taken as 0 on a pixel carrying the line strobe and after reset.
- R8: The input plus the offset saturates at 4095 before the low bits are dropped.
- R9: Outputs and strobes appear exactly one clock after the input pixel. Reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Dithering enable |
| cfg_depth | input | 2 | Depth code: 0 six bits, 1 eight bits, 2/3 no dither |
| cfg_rgb_sep | input | 1 | Separate feedback taps per channel |
| cfg_frame_rand | input | 1 | Reseed at every frame strobe |
| cfg_highpass | input | 1 | High-pass filter the offset |
| seed_r | input | 28 | Red seed |
| seed_g | input | 28 | Green seed |
| seed_b | input | 28 | Blue seed |
| pix_valid | input | 1 | Input pixel valid |
| pix_sof | input | 1 | First pixel of frame |
| pix_sol | input | 1 | First pixel of line |
| pix_r | input | 12 | Red input |
| pix_g | input | 12 | Green input |
| pix_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed frame strobe |
| out_sol | output | 1 | Delayed line strobe |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
The bench builds the block with its default parameters: 12-bit inputs, 28-bit registers and a 4-bit frame count. With these values, an input of 4095 makes saturation reachable, and the 16-value frame count wraps within a short run. Both the 6-bit and the 8-bit output widths are exercised from the same build by changing the depth code. A reference model in the bench tracks the three registers, the frame count and the previous offsets from the stated rules. Streams in shared mode, separate mode, reseeding mode and high-pass mode are compared pixel by pixel.

// File: rtl/dith_pkg.sv
// Package: shared constants and helpers for the spatial dither unit.
// Assumes feedback polynomials of the form x^W + x^t + 1.
package dith_pkg;
    // Tap used by every channel in shared mode
    localparam int SHARED_TAP = 3;

    // Tap for a channel when taps are separate (0 red, 1 green, 2 blue)
    function automatic int sep_tap(input int ch);
        return (ch == 1) ? 9 : ((ch == 2) ? 13 : 3);
    endfunction
endpackage

// File: rtl/dith_lfsr.sv
// Module: one channel's 28-bit LFSR with seed load and selectable tap.
// Provides the state used for the current pixel (the load value on a
// reload pixel). Assumes seed is static between resets.
module dith_lfsr #(
    parameter int W       = 28,
    parameter int MIX_W   = 4,
    parameter int TAP_A   = 3,
    parameter int TAP_B   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     seed,
    input  logic             use_b,
    input  logic             load_en,
    input  logic [MIX_W-1:0] mix,
    input  logic             adv,
    output logic [W-1:0]     cur
);
    logic [W-1:0] state_q;
    logic [W-1:0] seed_fix;
    logic [W-1:0] load_val;
    logic         fb;

    // Zero-guarded seed and per-frame load value
    always_comb begin
        seed_fix = (seed == '0) ? W'(1) : seed;
        load_val = seed ^ {{(W-MIX_W){1'b0}}, mix};
        if (load_val == '0) load_val = W'(1);
        cur = load_en ? load_val : state_q;
        fb  = cur[W-1] ^ (use_b ? cur[TAP_B-1] : cur[TAP_A-1]);
    end

    // State register: seed at reset, one step per valid pixel
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= seed_fix;
        else if (adv) state_q <= {cur[W-2:0], fb};
    end

    assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/dith_frame_ctr.sv
// Module: frame counter for per-frame reseeding, with bit-reversed output.
// Counts valid frame strobes modulo 2^CNT_W while reseeding is on.
module dith_frame_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_rand,
    input  logic             step,
    output logic [CNT_W-1:0] mix
);
    logic [CNT_W-1:0] cnt_q;

    // Counter: held at zero with reseeding off, wraps at its maximum
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_rand) cnt_q <= '0;
        else if (step)             cnt_q <= cnt_q + 1'b1;
    end

    // Bit swap: reverse the count before mixing into the seed
    for (genvar i = 0; i < CNT_W; i++) begin : g_rev
        assign mix[i] = cnt_q[CNT_W-1-i];
    end

    assert_count_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rand && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/dith_chan.sv
// Module: one colour channel - offset shaping, saturating add, truncation
// and the output register. Assumes IN_W > HI_W > LO_W.
module dith_chan #(
    parameter int IN_W = 12,
    parameter int HI_W = 8,
    parameter int LO_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IN_W-1:0]       in_pix,
    input  logic                  pix_valid,
    input  logic                  pix_sol,
    input  logic [IN_W-LO_W-1:0]  raw,
    input  logic                  dith_on,
    input  logic                  narrow,
    input  logic                  highpass,
    output logic [HI_W-1:0]       out_q
);
    localparam int NZ_W   = IN_W - LO_W;
    localparam int WIDE_W = IN_W - HI_W;

    logic [NZ_W-1:0] prev_q;
    logic [NZ_W-1:0] prev_use;
    logic [NZ_W-1:0] noise;
    logic [IN_W:0]   sum;
    logic [IN_W-1:0] val;
    logic [HI_W-1:0] res;

    // Offset shaping, saturating add and truncation
    always_comb begin
        prev_use = pix_sol ? '0 : prev_q;
        noise    = highpass ? (raw ^ prev_use) : raw;
        if (!narrow) noise = noise & NZ_W'((1 << WIDE_W) - 1);
        sum = {1'b0, in_pix} + {{(IN_W+1-NZ_W){1'b0}}, noise};
        val = dith_on ? (sum[IN_W] ? '1 : sum[IN_W-1:0]) : in_pix;
        res = narrow ? {{(HI_W-LO_W){1'b0}}, val[IN_W-1 -: LO_W]}
                     : val[IN_W-1 -: HI_W];
    end

    // Previous raw offset for the high-pass option
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_q <= '0;
        else if (pix_valid) prev_q <= raw;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= res;
    end

    assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dith_on && !narrow) |=> out_q >= $past(in_pix[IN_W-1 -: HI_W]));
    assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dith_on && !narrow) |=> out_q == $past(in_pix[IN_W-1 -: HI_W]));
endmodule

// File: rtl/pix_lfsr_dither.sv
// Module: spatial LFSR dither unit, top level. Three channels, each with
// its own LFSR and shaping slice, plus a shared frame counter.
// Assumes configuration changes only while reset is asserted.
module pix_lfsr_dither #(
    parameter int IN_W   = 12,
    parameter int HI_W   = 8,
    parameter int LO_W   = 6,
    parameter int LFSR_W = 28,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_rgb_sep,
    input  logic              cfg_frame_rand,
    input  logic              cfg_highpass,
    input  logic [LFSR_W-1:0] seed_r,
    input  logic [LFSR_W-1:0] seed_g,
    input  logic [LFSR_W-1:0] seed_b,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic              pix_sol,
    input  logic [IN_W-1:0]   pix_r,
    input  logic [IN_W-1:0]   pix_g,
    input  logic [IN_W-1:0]   pix_b,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [HI_W-1:0]   out_r,
    output logic [HI_W-1:0]   out_g,
    output logic [HI_W-1:0]   out_b
);
    import dith_pkg::*;

    localparam int NCH  = 3;
    localparam int NZ_W = IN_W - LO_W;

    logic [LFSR_W-1:0] seeds [NCH];
    logic [IN_W-1:0]   ins   [NCH];
    logic [HI_W-1:0]   outs  [NCH];
    logic [CNT_W-1:0]  mix;
    logic              dith_on;
    logic              narrow;
    logic              reload;

    // Mode decode and channel fan-out
    always_comb begin
        dith_on  = cfg_enable && (cfg_depth < 2'd2);
        narrow   = (cfg_depth == 2'd0);
        reload   = pix_valid && pix_sof && cfg_frame_rand;
        seeds[0] = seed_r;
        seeds[1] = seed_g;
        seeds[2] = seed_b;
        ins[0]   = pix_r;
        ins[1]   = pix_g;
        ins[2]   = pix_b;
    end

    dith_frame_ctr #(.CNT_W(CNT_W)) u_fctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_rand (cfg_frame_rand),
        .step       (pix_valid && pix_sof),
        .mix        (mix)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [LFSR_W-1:0] cur;

        dith_lfsr #(
            .W     (LFSR_W),
            .MIX_W (CNT_W),
            .TAP_A (SHARED_TAP),
            .TAP_B (sep_tap(ch))
        ) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .seed    (seeds[ch]),
            .use_b   (cfg_rgb_sep),
            .load_en (reload),
            .mix     (mix),
            .adv     (pix_valid),
            .cur     (cur)
        );

        dith_chan #(.IN_W(IN_W), .HI_W(HI_W), .LO_W(LO_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_pix    (ins[ch]),
            .pix_valid (pix_valid),
            .pix_sol   (pix_sol),
            .raw       (cur[NZ_W-1:0]),
            .dith_on   (dith_on),
            .narrow    (narrow),
            .highpass  (cfg_highpass),
            .out_q     (outs[ch])
        );
    end

    // Strobe delay registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
        end else begin
            out_valid <= pix_valid;
            out_sof   <= pix_valid && pix_sof;
            out_sol   <= pix_valid && pix_sol;
        end
    end

    assign out_r = outs[0];
    assign out_g = outs[1];
    assign out_b = outs[2];

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid && !out_sof && !out_sol);
    assert_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_depth == 2'd0) |=> (out_r[HI_W-1:LO_W] == '0) &&
            (out_g[HI_W-1:LO_W] == '0) && (out_b[HI_W-1:LO_W] == '0));
endmodule

// File: tb/pix_lfsr_dither_tb_top.sv
module pix_lfsr_dither_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_depth = 2'd1;
    logic        cfg_rgb_sep = 1'b0;
    logic        cfg_frame_rand = 1'b0;
    logic        cfg_highpass = 1'b0;
    logic [27:0] seed [3];
    logic        pix_valid = 1'b0;
    logic        pix_sof = 1'b0;
    logic        pix_sol = 1'b0;
    logic [11:0] pix_r = '0;
    logic [11:0] pix_g = '0;
    logic [11:0] pix_b = '0;
    logic        out_valid, out_sof, out_sol;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [27:0] m_s [3];
    logic [5:0]  m_prev [3];
    logic [3:0]  m_cnt;

    always #2 clk = ~clk;

    pix_lfsr_dither dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_depth(cfg_depth),
        .cfg_rgb_sep(cfg_rgb_sep), .cfg_frame_rand(cfg_frame_rand),
        .cfg_highpass(cfg_highpass), .seed_r(seed[0]), .seed_g(seed[1]),
        .seed_b(seed[2]), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_sol(pix_sol), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] fixz(input logic [27:0] v);
        return (v == '0) ? 28'd1 : v;
    endfunction

    function automatic logic [27:0] stp(input logic [27:0] s, input int tap);
        return {s[26:0], s[27] ^ s[tap-1]};
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    // Reset the DUT and the model, then check the reset state (R9, R4)
    task automatic do_reset();
        rst_n = 1'b0;
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 reset out_valid", 32'(out_valid), 0);
        check("R9 reset out_r", 32'(out_r), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            m_s[i] = fixz(seed[i]);
            m_prev[i] = '0;
        end
        m_cnt = '0;
    endtask

    // Drive one valid pixel, predict from the model, check one clock later
    task automatic px(input logic [11:0] r, input logic [11:0] g, input logic [11:0] b,
                      input logic sof, input logic sol, input string req);
        logic [11:0] ins [3];
        logic [7:0]  expv [3];
        logic [27:0] src;
        logic [5:0]  raw, nz;
        logic [12:0] sum;
        logic [11:0] v;
        int tap;
        ins[0] = r; ins[1] = g; ins[2] = b;
        for (int ch = 0; ch < 3; ch++) begin
            tap = (ch == 0 || !cfg_rgb_sep) ? 3 : ((ch == 1) ? 9 : 13);
            src = (sof && cfg_frame_rand) ? fixz(seed[ch] ^ {24'd0, rev4(m_cnt)}) : m_s[ch];
            raw = src[5:0];
            nz = cfg_highpass ? (raw ^ (sol ? 6'd0 : m_prev[ch])) : raw;
            if (cfg_depth != 2'd0) nz = nz & 6'h0F;
            sum = {1'b0, ins[ch]} + {7'd0, nz};
            v = sum[12] ? 12'hFFF : sum[11:0];
            if (!(cfg_enable && cfg_depth < 2'd2)) v = ins[ch];
            expv[ch] = (cfg_depth == 2'd0) ? {2'b00, v[11:6]} : v[11:4];
            m_s[ch] = stp(src, tap);
            m_prev[ch] = raw;
        end
        if (sof && cfg_frame_rand) m_cnt = m_cnt + 4'd1;
        pix_valid = 1'b1; pix_sof = sof; pix_sol = sol;
        pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        check({req, " valid"}, 32'(out_valid), 1);
        check({req, " sof"}, 32'(out_sof), 32'(sof));
        check({req, " sol"}, 32'(out_sol), 32'(sol));
        check({req, " r"}, 32'(out_r), 32'(expv[0]));
        check({req, " g"}, 32'(out_g), 32'(expv[1]));
        check({req, " b"}, 32'(out_b), 32'(expv[2]));
        pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic en, input logic [1:0] d, input logic sep,
                           input logic fr, input logic hp);
        rst_n = 1'b0;
        cfg_enable = en; cfg_depth = d; cfg_rgb_sep = sep;
        cfg_frame_rand = fr; cfg_highpass = hp;
        do_reset();
    endtask

    // R2, R1: plain truncation with hand-computed values
    task automatic t_passthru();
        set_cfg(1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
        px(12'hABC, 12'h123, 12'hFFF, 1'b1, 1'b1, "R2 trunc8");
        check("R2 hand r8", 32'(out_r), 32'h0AB);
        set_cfg(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        px(12'hABC, 12'h040, 12'hFFF, 1'b1, 1'b1, "R1 trunc6");
        check("R1 hand r6", 32'(out_r), 32'h2A);
        check("R1 hand b6", 32'(out_b), 32'h3F);
    endtask

    // R3, R5: shared taps, streams at both depths
    task automatic t_shared();
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++)
            px(12'(i * 97), 12'(i * 31 + 5), 12'(4000 - i * 13), i == 0, (i % 8) == 0, "R3 shared8");
        idle(3);
        for (int i = 0; i < 10; i++)
            px(12'(i * 211), 12'h7F0, 12'h008, 1'b0, 1'b0, "R5 gap");
        set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++)
            px(12'(i * 133), 12'(i * 17), 12'h3C0, i == 0, 1'b0, "R1 shared6");
    endtask

    // R3: separate taps
    task automatic t_sep();
        set_cfg(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++)
            px(12'(i * 67), 12'(i * 67), 12'(i * 67), 1'b0, 1'b0, "R3 separate");
    endtask

    // R4: zero seed replaced by 1; reseed off keeps stream on frame strobe
    task automatic t_seed();
        seed[0] = 28'd0; seed[1] = 28'h0000021; seed[2] = 28'hFFFFFFF;
        set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            px(12'h100, 12'h100, 12'h100, (i % 4) == 0, 1'b0, "R4 seed");
        seed[0] = 28'h5A5A5A5; seed[1] = 28'h1234567; seed[2] = 28'h0ABCDEF;
    endtask

    // R6: per-frame reseeding across a count wrap
    task automatic t_frame();
        set_cfg(1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
        for (int f = 0; f < 18; f++)
            for (int i = 0; i < 3; i++)
                px(12'(f * 50 + i), 12'h200, 12'h9C4, i == 0, i == 0, "R6 reseed");
    endtask

    // R7: high-pass, with line strobes clearing the history
    task automatic t_highpass();
        set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 36; i++)
            px(12'(i * 45), 12'h555, 12'hAAA, i == 0, (i % 6) == 0, "R7 highpass");
        set_cfg(1'b1, 2'd1, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++)
            px(12'h800, 12'h0F3, 12'h70D, 1'b0, (i % 5) == 0, "R7 highpass8");
    endtask

    // R8: saturation at full scale
    task automatic t_saturate();
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            px(12'hFFF, 12'hFFE, 12'hFF0, 1'b0, 1'b0, "R8 sat8");
            check("R8 hand r8", 32'(out_r), 32'hFF);
        end
        set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        px(12'hFFF, 12'hFC0, 12'hFFF, 1'b0, 1'b0, "R8 sat6");
        check("R8 hand b6", 32'(out_b), 32'h3F);
    endtask

    // R1: depth codes 2 and 3 give plain 8-bit truncation even when enabled
    task automatic t_depth_off();
        set_cfg(1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
        px(12'h123, 12'hFFF, 12'h00F, 1'b0, 1'b0, "R1 depth2");
        check("R1 hand depth2", 32'(out_r), 32'h12);
        set_cfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
        px(12'h45F, 12'h000, 12'h80F, 1'b0, 1'b0, "R1 depth3");
        check("R1 hand depth3", 32'(out_r), 32'h45);
    endtask

    // R9: output valid drops one clock after input valid
    task automatic t_latency();
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
        px(12'h300, 12'h300, 12'h300, 1'b1, 1'b1, "R9 latency");
        @(negedge clk);
        check("R9 idle valid", 32'(out_valid), 0);
        check("R9 idle sof", 32'(out_sof), 0);
    endtask

    initial begin
        seed[0] = 28'h5A5A5A5; seed[1] = 28'h1234567; seed[2] = 28'h0ABCDEF;
        t_passthru();
        t_shared();
        t_sep();
        t_seed();
        t_frame();
        t_highpass();
        t_saturate();
        t_depth_off();
        t_latency();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule